// File: doc/BRIEF.md
# Timer Input Capture Unit

This block records the time of an external event. It watches a trigger line and compares it with the value of a free-running 16-bit timer. When the chosen edge arrives, it stores the timer value in a capture register and sets a sticky capture flag. The flag also drives an interrupt request, which a mask bit can hold off.

The trigger can come from either of two places: a dedicated event pin, or the output of an analog comparator. A control bit picks the source. The selected signal passes through a two-flop synchroniser. An optional noise canceller can follow it; this filter changes its level only after four equal samples in a row. An edge detector then fires on the rising or the falling edge, as configured.

Software reaches the block through a small byte-wide register port with four addresses. Reading the low byte of the capture register copies the high byte into a holding register, so a 16-bit value read as two bytes is always consistent.

Top module: `tmr_capture_unit`

## Requirements
- R1: After reset, the control register reads 0x00, the status register reads 0x00, both capture bytes read 0x00 and `irq` is low.
- R2: With the filter off, a qualifying edge on the selected source is captured 3 clocks after the cycle in which it is driven. The capture stores `tmr_count` as it stands at that clock edge, which is the count of the driving cycle plus 3.
- R3: Control bit 0 picks the capture edge: 1 captures on rising edges and 0 captures on falling edges. An edge of the opposite direction captures nothing.
- R4: Control bit 2 picks the trigger source: 0 selects `evt_pin` and 1 selects `cmp_out`. Activity on the source that is not selected sets no flag.
- R5: With control bit 1 set, the noise filter adds 4 clocks of latency, so the capture is taken at the driving cycle's count plus 7. A pulse shorter than 4 clocks causes no capture.
- R6: Every capture sets the status flag (address 1, bit 0). Writing 1 to that bit clears the flag, and the flag reads back 0 afterwards.
- R7: When a capture and a flag-clearing write fall in the same clock, the capture wins and the flag stays set.
- R8: `irq` is high exactly when the flag is set and control bit 3 (the interrupt mask) is 1.
- R9: A read of address 2 returns capture bits 7:0. The same read copies bits 15:8 into a holding register, and address 3 returns that holding register. A capture that happens between the two reads does not change the high byte that is returned.
- R10: Address 0 reads back control bits 3:0 as written, and its bits 7:4 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tmr_count | input | 16 | Current value of the free-running timer |
| evt_pin | input | 1 | External event pin (asynchronous) |
| cmp_out | input | 1 | Analog comparator output (asynchronous) |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; used by the capture low-byte read to load the holding register |
| bus_addr | input | 2 | Register address: 0 control, 1 status, 2 capture low, 3 capture high |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| irq | output | 1 | Capture interrupt request |

## Verification
The bench builds the block with its default parameters: a 16-bit count and a four-sample filter. With these values both the filtered and the unfiltered latency come out as small fixed offsets from the count. The bench sweeps every combination of source, edge polarity and filter enable. In each combination it checks the capture value arithmetically, shows that the unselected source and the opposite edge have no effect, and shows that a short glitch is rejected. Directed tests place a flag clear exactly on the capture clock, test the interrupt mask, and let a second capture land between the two halves of a read, with the timer far enough ahead that the high byte has changed.

// File: rtl/tcu_pkg.sv
package tcu_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_CAPL = 2'd2;
  localparam logic [1:0] ADDR_CAPH = 2'd3;

  // control register layout, bit 3 down to bit 0
  typedef struct packed {
    logic irq_en;
    logic src_cmp;
    logic filt_en;
    logic pol_rise;
  } tcu_ctrl_t;
endpackage

// File: rtl/tcu_trig_filter.sv
// Two-flop synchroniser followed by an optional N-sample majority-free filter.
module tcu_trig_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic filt_en,
  output logic lvl
);
  logic                s1_q, s2_q;
  logic [FILT_LEN-1:0] hist_q, hist_d;
  logic                lvl_q, lvl_d;
  logic                all_hi, all_lo;

  assign all_hi = &hist_q;
  assign all_lo = ~|hist_q;
  assign hist_d = {hist_q[FILT_LEN-2:0], s2_q};

  always_comb begin
    if (!filt_en)    lvl_d = s2_q;
    else if (all_hi) lvl_d = 1'b1;
    else if (all_lo) lvl_d = 1'b0;
    else             lvl_d = lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      hist_q <= '0;
      lvl_q  <= 1'b0;
    end else begin
      s1_q   <= raw;
      s2_q   <= s1_q;
      hist_q <= hist_d;
      lvl_q  <= lvl_d;
    end
  end

  assign lvl = lvl_q;
endmodule

// File: rtl/tcu_edge_sel.sv
// Polarity-selectable single-cycle edge detector.
module tcu_edge_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic pol_rise,
  output logic evt
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign evt = pol_rise ? (lvl & ~prev_q) : (~lvl & prev_q);
endmodule

// File: rtl/tmr_capture_unit.sv
module tmr_capture_unit
  import tcu_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int FILT_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tmr_count,
  input  logic             evt_pin,
  input  logic             cmp_out,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  output logic             irq
);
  localparam int HI_W = CNT_W - 8;

  // reset: asserted asynchronously, released on a clock edge
  logic rs1_q, rs2_q, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_int_n = rs2_q;

  tcu_ctrl_t        ctrl_q, ctrl_d;
  logic             flag_q, flag_d;
  logic [CNT_W-1:0] cap_q, cap_d;
  logic [HI_W-1:0]  tmp_q, tmp_d;
  logic             src_sel, trig_lvl, cap_evt;
  logic             wr_ctrl, clr_flag, rd_low;
  logic             unused_wdata;

  assign src_sel = ctrl_q.src_cmp ? cmp_out : evt_pin;

  tcu_trig_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst_n(rst_int_n), .raw(src_sel),
    .filt_en(ctrl_q.filt_en), .lvl(trig_lvl)
  );

  tcu_edge_sel u_edge (
    .clk(clk), .rst_n(rst_int_n), .lvl(trig_lvl),
    .pol_rise(ctrl_q.pol_rise), .evt(cap_evt)
  );

  assign wr_ctrl      = bus_wr && (bus_addr == ADDR_CTRL);
  assign clr_flag     = bus_wr && (bus_addr == ADDR_STAT) && bus_wdata[0];
  assign rd_low       = bus_rd && (bus_addr == ADDR_CAPL);
  assign unused_wdata = ^bus_wdata[7:4];

  // next state
  always_comb begin
    ctrl_d = wr_ctrl ? tcu_ctrl_t'(bus_wdata[3:0]) : ctrl_q;
    cap_d  = cap_evt ? tmr_count : cap_q;
    tmp_d  = rd_low  ? cap_q[CNT_W-1:8] : tmp_q;
    if (cap_evt)       flag_d = 1'b1;   // capture beats clear
    else if (clr_flag) flag_d = 1'b0;
    else               flag_d = flag_q;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ctrl_q <= '0;
      flag_q <= 1'b0;
      cap_q  <= '0;
      tmp_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      flag_q <= flag_d;
      cap_q  <= cap_d;
      tmp_q  <= tmp_d;
    end
  end

  // read mux
  always_comb begin
    case (bus_addr)
      ADDR_CTRL: bus_rdata = {4'b0000, ctrl_q};
      ADDR_STAT: bus_rdata = {7'b0000000, flag_q};
      ADDR_CAPL: bus_rdata = cap_q[7:0];
      default:   bus_rdata = 8'(tmp_q);
    endcase
  end

  assign irq = flag_q & ctrl_q.irq_en;
endmodule

// File: rtl/tcu_checker.sv
module tcu_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [1:0]       bus_addr,
  input logic             wdata0,
  input logic [CNT_W-1:0] tmr_count,
  input logic             cap_evt,
  input logic             flag,
  input logic [CNT_W-1:0] cap,
  input logic [CNT_W-9:0] tmp,
  input logic             irq
);
  logic clr_w;
  assign clr_w = bus_wr && (bus_addr == 2'd1) && wdata0;

  a_r2_capture_loads: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> cap == $past(tmr_count));
  a_r2_cap_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> $stable(cap));
  a_r6_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> flag);
  a_r6_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_w && !cap_evt) |=> !flag);
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_w) |=> flag);
  a_r7_capture_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_w && cap_evt) |=> flag);
  a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_addr == 2'd2) |=> $stable(tmp));
endmodule

bind tmr_capture_unit tcu_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .wdata0(bus_wdata[0]), .tmr_count(tmr_count),
  .cap_evt(cap_evt), .flag(flag_q), .cap(cap_q), .tmp(tmp_q), .irq(irq)
);

// File: tb/tb_tmr_capture_unit.sv
`timescale 1ns/1ps
module tb_tmr_capture_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tcount = 16'h0000;
  logic        evt_pin = 1'b0, cmp_out = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic        irq;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) tcount <= tcount + 16'd1;

  tmr_capture_unit dut (
    .clk(clk), .rst_n(rst_n), .tmr_count(tcount), .evt_pin(evt_pin),
    .cmp_out(cmp_out), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = 8'h00;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic drive(input bit src, input bit v);
    if (src) cmp_out = v; else evt_pin = v;
  endtask

  task automatic sweep_case(input bit src, input bit rise, input bit filt);
    logic [7:0]  f, lo, hi;
    logic [15:0] c;
    int          lat;
    lat = filt ? 7 : 3;
    wr(2'd0, {4'b0000, 1'b0, src, filt, rise});
    evt_pin = ~rise; cmp_out = ~rise;
    idle(12);
    wr(2'd1, 8'h01);
    rd(2'd1, f); check("R6 flag cleared by write", f, 0);
    drive(~src, rise); idle(12);
    drive(~src, ~rise); idle(12);
    rd(2'd1, f); check("R4 unselected source ignored", f, 0);
    @(negedge clk); c = tcount; drive(src, rise);
    idle(12);
    rd(2'd1, f); check("R6 flag set on capture", f, 1);
    rd(2'd2, lo); rd(2'd3, hi);
    if (filt) check("R5 filtered capture value", {hi, lo}, int'(c + 16'(lat)));
    else      check("R2 capture value", {hi, lo}, int'(c + 16'(lat)));
    wr(2'd1, 8'h01);
    drive(src, ~rise); idle(12);
    rd(2'd1, f); check("R3 opposite edge ignored", f, 0);
    if (filt) begin
      drive(src, rise); idle(3); drive(src, ~rise); idle(12);
      rd(2'd1, f); check("R5 short pulse rejected", f, 0);
    end
  endtask

  initial begin
    logic [7:0]  f, lo, hi;
    logic [15:0] ca, cb;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    rd(2'd0, f); check("R1 ctrl reset", f, 0);
    rd(2'd1, f); check("R1 status reset", f, 0);
    rd(2'd2, lo); rd(2'd3, hi); check("R1 capture reset", {hi, lo}, 0);
    check("R1 irq reset", irq, 0);

    for (int s = 0; s < 2; s++)
      for (int r = 0; r < 2; r++)
        for (int fl = 0; fl < 2; fl++)
          sweep_case(s[0], r[0], fl[0]);

    // R7 clear in the capture clock, then clear one clock later
    wr(2'd0, 8'h01); evt_pin = 1'b0; cmp_out = 1'b0; idle(12);
    wr(2'd1, 8'h01);
    @(negedge clk); evt_pin = 1'b1; idle(2);
    wr(2'd1, 8'h01);
    rd(2'd1, f); check("R7 capture wins over clear", f, 1);
    evt_pin = 1'b0; idle(12); wr(2'd1, 8'h01);
    @(negedge clk); evt_pin = 1'b1; idle(3);
    wr(2'd1, 8'h01);
    rd(2'd1, f); check("R6 clear after capture", f, 0);

    // R9 atomic read across a later capture
    evt_pin = 1'b0; idle(12);
    @(negedge clk); ca = tcount; evt_pin = 1'b1; idle(12);
    rd(2'd2, lo); check("R9 low byte", lo, int'(8'(ca + 16'd3)));
    evt_pin = 1'b0; idle(300);
    @(negedge clk); cb = tcount; evt_pin = 1'b1; idle(12);
    rd(2'd3, hi); check("R9 held high byte", hi, int'((ca + 16'd3) >> 8));
    rd(2'd2, lo); rd(2'd3, hi); check("R9 new capture", {hi, lo}, int'(cb + 16'd3));

    // R8 interrupt mask (flag is set here)
    #1 check("R8 masked irq", irq, 0);
    wr(2'd0, 8'h09); #1 check("R8 irq with mask", irq, 1);
    wr(2'd0, 8'h01); #1 check("R8 irq mask removed", irq, 0);
    wr(2'd0, 8'h09); wr(2'd1, 8'h01); #1 check("R8 irq after clear", irq, 0);

    // R10 control readback
    wr(2'd0, 8'hF6); rd(2'd0, f); check("R10 ctrl readback", f, 8'h06);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule